// File: doc/BRIEF.md
# Integer Execute Unit

A purely combinational execute stage for a 32-bit load/store integer core with fixed 32-bit instruction words. The instruction word and the two register operands go in; a 32-bit result and an illegal-operation flag come out. The unit covers three families: two-operand arithmetic/logic on registers, the same operations against a sign-extended 16-bit immediate (plus a move-to-upper-half operation), and compares that write 1 or 0, with a register form and an immediate form.

The instruction word is laid out as {primary[31:28], dest[27:24], srcA[23:20], srcB[19:16], imm[15:0]}. The upstream stage reads the register file and presents the first source as `opnd_a` and the second as `opnd_b`. The result goes to write-back. `illegal` marks words that this unit does not execute. When `illegal` is 1, the result is forced to zero.

Condition codes are built so that a code with bit 3 set is the logical inverse of the same code with bit 3 clear. The same condition table can therefore serve a branch unit.

Top module: `int_exec_unit`

## Requirements
- R1: The family is selected by the primary opcode insn[31:28]:
  - 0000 selects register ALU.
  - 1000 selects immediate ALU.
  - 0010 selects register compare.
  - 1010 selects immediate compare.
  - Any other primary gives result 0 and illegal=1.
  - Every legal operation gives illegal=0.
- R2: In the register families, the operation code is insn[3:0] and the second operand is `opnd_b`. When insn[11:4] is not zero, the word gives result 0 and illegal=1. The bits insn[15:12] have no effect.
- R3: In the immediate families, the operation code is insn[19:16] and the second operand is insn[15:0] sign-extended to 32 bits. `opnd_b` has no effect.
- R4: The ALU codes are:
  - 0000 ADD (a+b, modulo 2^32)
  - 0001 SUB (a-b)
  - 0100 AND
  - 0101 OR
  - 0110 XOR
  - 1100 NAND
  - 1101 NOR
  - 1110 XNOR
- R5: ALU code 1011 in the immediate family gives {insn[15:0], 16'h0000}. In the register family, code 1011 is illegal.
- R6: A legal compare gives exactly 32'd1 when its condition holds and 32'd0 otherwise.
- R7: The compare codes use signed two's-complement order:
  - 0000 false
  - 1000 true
  - 0001 EQ
  - 1001 NE
  - 0010 LT
  - 1010 GTE
  - 0011 LTE
  - 1011 GT
- R8: The zero-test codes compare `opnd_a` with 0 and ignore the second operand:
  - 0101 EQZ
  - 1101 NEZ
  - 0111 LTEZ
  - 1111 GTZ
- R9: The following codes give result 0 and illegal=1:
  - ALU codes 0010, 0011, 0111, 1000, 1001, 1010 and 1111.
  - Compare codes 0100, 0110, 1100 and 1110.
- R10: For every legal compare code c with c[3]=0, code c|1000 gives the inverted result for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word {primary, dest, srcA, srcB, imm} |
| opnd_a | input | 32 | First source register value |
| opnd_b | input | 32 | Second source register value |
| result | output | 32 | Value to write back; zero when illegal |
| illegal | output | 1 | Word is not an operation this unit executes |

## Verification
The bench sweeps every primary opcode and every 4-bit secondary code against six operand pairs:
- Zero against zero and equal values separate EQ from the ordering codes.
- Small ascending values set the direction of LT and GT.
- Negative against positive, and the most-negative against the most-positive word, separate signed order from unsigned order and expose a wrapping subtractor.

For the immediate families, the immediates include 0x8000 and 0xFFFF to exercise sign extension. Further checks:
- Pairs of stimuli that differ only in `opnd_b` or in insn[15:12] show that the second operand and those bits are ignored where required.
- Non-zero padding bits in the register families must be flagged as illegal.
- Each complementary condition pair is driven back to back to confirm the inversion.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

   typedef enum logic [2:0] {
      FAM_BAD  = 3'd0,
      FAM_ALUR = 3'd1,
      FAM_ALUI = 3'd2,
      FAM_CMPR = 3'd3,
      FAM_CMPI = 3'd4
   } fam_e;

   localparam logic [3:0] PRI_ALUR = 4'b0000;
   localparam logic [3:0] PRI_ALUI = 4'b1000;
   localparam logic [3:0] PRI_CMPR = 4'b0010;
   localparam logic [3:0] PRI_CMPI = 4'b1010;

   localparam logic [3:0] AOP_ADD  = 4'b0000;
   localparam logic [3:0] AOP_SUB  = 4'b0001;
   localparam logic [3:0] AOP_AND  = 4'b0100;
   localparam logic [3:0] AOP_OR   = 4'b0101;
   localparam logic [3:0] AOP_XOR  = 4'b0110;
   localparam logic [3:0] AOP_HIGH = 4'b1011;
   localparam logic [3:0] AOP_NAND = 4'b1100;
   localparam logic [3:0] AOP_NOR  = 4'b1101;
   localparam logic [3:0] AOP_XNOR = 4'b1110;

   // Compare code layout: bit3 inverts, bit2 selects zero test,
   // bits 1:0 pick the base relation (00 none, 01 eq, 10 lt, 11 lte).
   localparam int CC_INV_BIT  = 3;
   localparam int CC_ZERO_BIT = 2;

   localparam int PAD_W = 8;

endpackage

// File: rtl/exu_field_decode.sv
module exu_field_decode
   import int_exec_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int OPC_W  = 4,
   parameter int RIDX_W = 4,
   localparam int INSN_W = OPC_W + 3 * RIDX_W + IMM_W
) (
   input  logic [INSN_W-1:0] insn,
   output fam_e              fam,
   output logic [RIDX_W-1:0] sec_code,
   output logic              pad_nz,
   output logic [IMM_W-1:0]  imm_raw,
   output logic [DATA_W-1:0] imm_ext
);

   localparam int SRCB_LO = IMM_W;
   localparam int EXT_W   = DATA_W - IMM_W;

   logic [OPC_W-1:0]  prim;
   logic [RIDX_W-1:0] srcb_field;
   logic              unused_fields;

   assign prim       = insn[INSN_W-1 -: OPC_W];
   assign srcb_field = insn[SRCB_LO +: RIDX_W];
   assign imm_raw    = insn[IMM_W-1:0];
   assign imm_ext    = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};
   assign pad_nz     = |imm_raw[RIDX_W +: PAD_W];
   assign unused_fields = ^insn[INSN_W-OPC_W-1 -: 2*RIDX_W];

   always_comb begin
      unique case (prim)
         PRI_ALUR: fam = FAM_ALUR;
         PRI_ALUI: fam = FAM_ALUI;
         PRI_CMPR: fam = FAM_CMPR;
         PRI_CMPI: fam = FAM_CMPI;
         default:  fam = FAM_BAD;
      endcase
   end

   generate
      if (RIDX_W == 4) begin : g_sec_direct
         always_comb begin
            if (fam == FAM_ALUI || fam == FAM_CMPI) sec_code = srcb_field;
            else                                    sec_code = imm_raw[RIDX_W-1:0];
         end
      end else begin : g_sec_bad
         assign sec_code = '0;
      end
   endgenerate

endmodule

// File: rtl/exu_alu.sv
module exu_alu
   import int_exec_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 16,
   parameter bit SHARED_ADD = 1'b1
) (
   input  logic [3:0]        code,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [IMM_W-1:0]  imm_raw,
   input  logic              allow_high,
   output logic [DATA_W-1:0] res,
   output logic              ok
);

   localparam int LOW_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] diff;

   generate
      if (SHARED_ADD) begin : g_one_adder
         logic              do_sub;
         logic [DATA_W-1:0] b_eff;
         logic [DATA_W-1:0] addout;
         assign do_sub = (code == AOP_SUB);
         assign b_eff  = do_sub ? ~b : b;
         assign addout = a + b_eff + {{(DATA_W-1){1'b0}}, do_sub};
         assign sum    = addout;
         assign diff   = addout;
      end else begin : g_two_adders
         assign sum  = a + b;
         assign diff = a - b;
      end
   endgenerate

   always_comb begin
      ok  = 1'b1;
      res = '0;
      case (code)
         AOP_ADD:  res = sum;
         AOP_SUB:  res = diff;
         AOP_AND:  res = a & b;
         AOP_OR:   res = a | b;
         AOP_XOR:  res = a ^ b;
         AOP_NAND: res = ~(a & b);
         AOP_NOR:  res = ~(a | b);
         AOP_XNOR: res = ~(a ^ b);
         AOP_HIGH: begin
            ok  = allow_high;
            res = allow_high ? {imm_raw, {LOW_W{1'b0}}} : '0;
         end
         default:  ok = 1'b0;
      endcase
   end

   always_comb begin
      if (code == AOP_ADD) begin
         assert_add_inverse_R4: assert (res - b == a)
            else $error("ADD result does not invert by subtraction");
      end
      if (code == AOP_SUB) begin
         assert_sub_inverse_R4: assert (res + b == a)
            else $error("SUB result does not invert by addition");
      end
      if (code == AOP_HIGH && ok) begin
         assert_high_low_clear_R5: assert (res[LOW_W-1:0] == '0)
            else $error("move-high left low bits set");
      end
   end

endmodule

// File: rtl/exu_compare.sv
module exu_compare
   import int_exec_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit VIA_SUB = 1'b1
) (
   input  logic [3:0]        cond,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              hit,
   output logic              ok
);

   logic [DATA_W-1:0] rhs;
   logic              eq;
   logic              lt;
   logic              base;

   assign rhs = cond[CC_ZERO_BIT] ? '0 : b;
   assign eq  = (a == rhs);

   generate
      if (VIA_SUB) begin : g_lt_sub
         logic [DATA_W:0] wide_diff;
         assign wide_diff = {a[DATA_W-1], a} - {rhs[DATA_W-1], rhs};
         assign lt        = wide_diff[DATA_W];
      end else begin : g_lt_native
         assign lt = ($signed(a) < $signed(rhs));
      end
   endgenerate

   always_comb begin
      case (cond[1:0])
         2'b00:   base = 1'b0;
         2'b01:   base = eq;
         2'b10:   base = lt;
         default: base = eq | lt;
      endcase
   end

   assign ok  = !(cond[CC_ZERO_BIT] && !cond[0]);
   assign hit = base ^ cond[CC_INV_BIT];

   always_comb begin
      assert_eq_lt_exclusive_R7: assert (!(eq && lt))
         else $error("operands reported both equal and less");
   end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import int_exec_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 16,
   parameter int OPC_W      = 4,
   parameter int RIDX_W     = 4,
   parameter bit SHARED_ADD = 1'b1,
   parameter bit CMP_BY_SUB = 1'b1,
   localparam int INSN_W    = OPC_W + 3 * RIDX_W + IMM_W
) (
   input  logic [INSN_W-1:0] insn,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] result,
   output logic              illegal
);

   initial begin
      if (OPC_W != 4 || RIDX_W != 4)
         $fatal(1, "opcode and register-index fields must be 4 bits");
      if (IMM_W < RIDX_W + PAD_W)
         $fatal(1, "immediate too narrow for code plus padding");
      if (DATA_W <= IMM_W)
         $fatal(1, "data path must be wider than the immediate");
   end

   fam_e              fam;
   logic [RIDX_W-1:0] sec_code;
   logic              pad_nz;
   logic [IMM_W-1:0]  imm_raw;
   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] opnd2;
   logic [DATA_W-1:0] alu_res;
   logic              alu_ok;
   logic              cmp_hit;
   logic              cmp_ok;
   logic              is_imm;
   logic              is_reg;
   logic              is_alu;
   logic              is_cmp;

   exu_field_decode #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W),
      .OPC_W  (OPC_W),
      .RIDX_W (RIDX_W)
   ) u_decode (
      .insn     (insn),
      .fam      (fam),
      .sec_code (sec_code),
      .pad_nz   (pad_nz),
      .imm_raw  (imm_raw),
      .imm_ext  (imm_ext)
   );

   assign is_imm = (fam == FAM_ALUI) || (fam == FAM_CMPI);
   assign is_reg = (fam == FAM_ALUR) || (fam == FAM_CMPR);
   assign is_alu = (fam == FAM_ALUR) || (fam == FAM_ALUI);
   assign is_cmp = (fam == FAM_CMPR) || (fam == FAM_CMPI);
   assign opnd2  = is_imm ? imm_ext : opnd_b;

   exu_alu #(
      .DATA_W     (DATA_W),
      .IMM_W      (IMM_W),
      .SHARED_ADD (SHARED_ADD)
   ) u_alu (
      .code       (sec_code),
      .a          (opnd_a),
      .b          (opnd2),
      .imm_raw    (imm_raw),
      .allow_high (fam == FAM_ALUI),
      .res        (alu_res),
      .ok         (alu_ok)
   );

   exu_compare #(
      .DATA_W  (DATA_W),
      .VIA_SUB (CMP_BY_SUB)
   ) u_cmp (
      .cond (sec_code),
      .a    (opnd_a),
      .b    (opnd2),
      .hit  (cmp_hit),
      .ok   (cmp_ok)
   );

   always_comb begin
      illegal = (fam == FAM_BAD)
              | (is_reg & pad_nz)
              | (is_alu & ~alu_ok)
              | (is_cmp & ~cmp_ok);
      if (illegal)     result = '0;
      else if (is_cmp) result = {{(DATA_W-1){1'b0}}, cmp_hit};
      else             result = alu_res;
   end

   always_comb begin
      if (illegal) begin
         assert_illegal_zero_R9: assert (result == '0)
            else $error("illegal word produced non-zero result");
      end
      if (is_cmp && !illegal) begin
         assert_cmp_boolean_R6: assert (result[DATA_W-1:1] == '0)
            else $error("compare produced more than one bit");
      end
      if (is_reg && pad_nz) begin
         assert_pad_flagged_R2: assert (illegal)
            else $error("register word with padding bits not flagged");
      end
      if (fam == FAM_BAD) begin
         assert_primary_flagged_R1: assert (illegal)
            else $error("unknown primary opcode not flagged");
      end
   end

endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] insn = '0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [31:0] result;
   logic        illegal;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   int_exec_unit u_int_exec_unit (
      .insn    (insn),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .result  (result),
      .illegal (illegal)
   );

   typedef struct {
      logic [31:0] res;
      logic        ill;
      string       tag;
   } exp_t;

   exp_t scb[$];

   function automatic logic [31:0] w_reg(input logic [3:0] prim, input logic [3:0] code,
                                         input logic [7:0] pad, input logic [3:0] top);
      return {prim, 4'd3, 4'd1, 4'd2, top, pad, code};
   endfunction

   function automatic logic [31:0] w_imm(input logic [3:0] prim, input logic [3:0] code,
                                         input logic [15:0] imm);
      return {prim, 4'd3, 4'd1, code, imm};
   endfunction

   function automatic void ref_alu(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                                   input bit imm_fam, input logic [15:0] imm,
                                   output logic [31:0] r, output logic ill);
      ill = 1'b0;
      r   = '0;
      case (c)
         4'd0:  r = a + b;
         4'd1:  r = a - b;
         4'd4:  r = a & b;
         4'd5:  r = a | b;
         4'd6:  r = a ^ b;
         4'd12: r = ~(a & b);
         4'd13: r = ~(a | b);
         4'd14: r = ~(a ^ b);
         4'd11: if (imm_fam) r = {imm, 16'h0000}; else ill = 1'b1;
         default: ill = 1'b1;
      endcase
   endfunction

   function automatic void ref_cmp(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                                   output logic [31:0] r, output logic ill);
      logic t;
      ill = 1'b0;
      t   = 1'b0;
      case (c)
         4'd0:  t = 1'b0;
         4'd8:  t = 1'b1;
         4'd1:  t = (a == b);
         4'd9:  t = (a != b);
         4'd2:  t = ($signed(a) <  $signed(b));
         4'd10: t = ($signed(a) >= $signed(b));
         4'd3:  t = ($signed(a) <= $signed(b));
         4'd11: t = ($signed(a) >  $signed(b));
         4'd5:  t = (a == 32'd0);
         4'd13: t = (a != 32'd0);
         4'd7:  t = ($signed(a) <= 0);
         4'd15: t = ($signed(a) >  0);
         default: ill = 1'b1;
      endcase
      r = ill ? 32'd0 : {31'd0, t};
   endfunction

   function automatic void ref_model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                                     output logic [31:0] r, output logic ill);
      logic [31:0] sx;
      sx = {{16{w[15]}}, w[15:0]};
      r = '0;
      ill = 1'b0;
      case (w[31:28])
         4'b0000: if (w[11:4] != 0) ill = 1'b1; else ref_alu(w[3:0], a, b, 1'b0, w[15:0], r, ill);
         4'b1000: ref_alu(w[19:16], a, sx, 1'b1, w[15:0], r, ill);
         4'b0010: if (w[11:4] != 0) ill = 1'b1; else ref_cmp(w[3:0], a, b, r, ill);
         4'b1010: ref_cmp(w[19:16], a, sx, r, ill);
         default: ill = 1'b1;
      endcase
      if (ill) r = '0;
   endfunction

   task automatic drive_exp(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] er, input logic eill, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      insn   = w;
      opnd_a = a;
      opnd_b = b;
      e.res = er;
      e.ill = eill;
      e.tag = tag;
      scb.push_back(e);
   endtask

   task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                        input string tag);
      logic [31:0] r;
      logic        il;
      ref_model(w, a, b, r, il);
      drive_exp(w, a, b, r, il, tag);
   endtask

   always @(negedge clk) begin
      if (!rst && scb.size() > 0) begin
         exp_t e;
         e = scb.pop_front();
         checks++;
         if (result !== e.res || illegal !== e.ill) begin
            fails++;
            $display("FAIL %s insn=%h a=%h b=%h: got result=%h illegal=%b, expected result=%h illegal=%b",
                     e.tag, insn, opnd_a, opnd_b, result, illegal, e.res, e.ill);
         end
      end
   end

   logic [31:0] pa [6] = '{32'h0, 32'h5, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
   logic [31:0] pb [6] = '{32'h0, 32'h5, 32'h2, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF};
   logic [15:0] pi [6] = '{16'h0000, 16'h0005, 16'h0002, 16'h0001, 16'h8000, 16'hFFFF};

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R1: all-zero word is register ADD of zero operands
      drive_exp(32'h0, 32'h0, 32'h0, 32'h0, 1'b0, "R1 idle zero word");

      // Hand-computed points
      drive_exp(w_reg(4'b0000, 4'd0, 8'h00, 4'h0), 32'd5, 32'd7, 32'd12, 1'b0, "R4 ADD");
      drive_exp(w_reg(4'b0000, 4'd1, 8'h00, 4'h0), 32'd3, 32'd5, 32'hFFFF_FFFE, 1'b0, "R4 SUB wraps");
      drive_exp(w_reg(4'b0000, 4'd12, 8'h00, 4'h0), 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FFF_0FFF, 1'b0, "R4 NAND");
      drive_exp(w_imm(4'b1000, 4'd11, 16'h1234), 32'hDEAD_BEEF, 32'h1, 32'h1234_0000, 1'b0, "R5 move-high");
      drive_exp(w_reg(4'b0000, 4'd11, 8'h00, 4'h0), 32'h1, 32'h1, 32'h0, 1'b1, "R5 move-high in reg family");
      drive_exp(w_imm(4'b1000, 4'd0, 16'hFFFF), 32'd10, 32'h55, 32'd9, 1'b0, "R3 ADDI sign-extended -1");
      drive_exp(w_imm(4'b1000, 4'd0, 16'hFFFF), 32'd10, 32'hAAAA_0000, 32'd9, 1'b0, "R3 opnd_b ignored");
      drive_exp(w_reg(4'b0010, 4'd2, 8'h00, 4'h0), 32'hFFFF_FFFF, 32'd1, 32'd1, 1'b0, "R7 LT signed");
      drive_exp(w_reg(4'b0010, 4'd11, 8'h00, 4'h0), 32'h8000_0000, 32'h7FFF_FFFF, 32'd0, 1'b0, "R7 GT min vs max");
      drive_exp(w_reg(4'b0010, 4'd0, 8'h00, 4'h0), 32'd4, 32'd4, 32'd0, 1'b0, "R7 false");
      drive_exp(w_reg(4'b0010, 4'd8, 8'h00, 4'h0), 32'd4, 32'd9, 32'd1, 1'b0, "R6 true gives one");
      drive_exp(w_imm(4'b1010, 4'd15, 16'h0000), 32'd0, 32'd0, 32'd0, 1'b0, "R8 GTZ of zero");
      drive_exp(w_reg(4'b0010, 4'd5, 8'h00, 4'h0), 32'd0, 32'd77, 32'd1, 1'b0, "R8 EQZ ignores b");
      drive_exp(w_reg(4'b0010, 4'd7, 8'h00, 4'h0), 32'hFFFF_FFF0, 32'h8000_0000, 32'd1, 1'b0, "R8 LTEZ negative");
      drive_exp(w_reg(4'b0000, 4'd0, 8'h10, 4'h0), 32'd1, 32'd1, 32'd0, 1'b1, "R2 padding bits set");
      drive_exp(w_reg(4'b0010, 4'd1, 8'h80, 4'h0), 32'd1, 32'd1, 32'd0, 1'b1, "R2 compare padding set");
      drive_exp(w_reg(4'b0000, 4'd5, 8'h00, 4'hF), 32'h0F00, 32'h00F0, 32'h0FF0, 1'b0, "R2 bits 15:12 ignored");
      drive_exp(w_imm(4'b0101, 4'd0, 16'h0004), 32'd1, 32'd1, 32'd0, 1'b1, "R1 other primary");
      drive_exp(w_reg(4'b0000, 4'd7, 8'h00, 4'h0), 32'd9, 32'd9, 32'd0, 1'b1, "R9 unused ALU code");
      drive_exp(w_imm(4'b1010, 4'd12, 16'h0000), 32'd0, 32'd0, 32'd0, 1'b1, "R9 unused compare code");

      // Full sweep against the reference model: R1 R2 R3 R4 R5 R6 R7 R8 R9
      for (int p = 0; p < 16; p++) begin
         for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 6; k++) begin
               if (p[3]) drive(w_imm(p[3:0], c[3:0], pi[k]), pa[k], pb[k], "R1-sweep imm");
               else      drive(w_reg(p[3:0], c[3:0], 8'h00, 4'h0), pa[k], pb[k], "R1-sweep reg");
            end
         end
      end

      // R10: complementary pairs invert
      for (int c = 0; c < 8; c++) begin
         if (c == 4 || c == 6) continue;
         for (int k = 0; k < 6; k++) begin
            logic [31:0] r0;
            logic        i0;
            ref_model(w_reg(4'b0010, c[3:0], 8'h00, 4'h0), pa[k], pb[k], r0, i0);
            drive(w_reg(4'b0010, c[3:0], 8'h00, 4'h0), pa[k], pb[k], "R10 base code");
            drive_exp(w_reg(4'b0010, c[3:0] | 4'b1000, 8'h00, 4'h0), pa[k], pb[k],
                      {31'd0, ~r0[0]}, 1'b0, "R10 inverted code");
         end
      end

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: bench did not finish, got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule